// File: doc/BRIEF.md
# Indexed Effective Address Generator

This block forms the 16-bit operand or jump-target address for the indexed addressing forms of an 8/16-bit microcontroller core. The decoder presents one request per `start` pulse. The request names a base register (X, Y, stack pointer or program counter) and supplies the current values of all four. It also gives an offset source, which is a signed literal of short, medium or full width, or one of the accumulators. The request can also ask for an auto-modify of the base or for a single memory-indirect hop.

A request without indirection completes in one cycle. An indirect request uses base plus offset as a pointer and reads two bytes through a byte-wide request/valid port, high byte first. The assembled 16-bit word becomes the effective address. Auto-modify adds or subtracts a step of 1 to 8 to the base register. Pre-modify uses the changed base as the address, and post-modify uses the original base. In both cases the changed value goes back to the register file with a one-cycle write enable. Auto-modify is refused when combined with indirection or an accumulator offset.

Top module: `idx_ea_gen`

## Requirements
- R1: A request with `off_src`=0 adds a constant offset taken from `cval`. It is sign-extended from bit 4 when `cwidth`=0, from bit 8 when `cwidth`=1, and used whole when `cwidth` is 2 or 3. The sum wraps modulo 2^16. `ea` and `done` appear in the cycle after `start` is sampled.
- R2: `base_sel` picks the base register with 0=X (`reg_x`), 1=Y (`reg_y`), 2=stack pointer (`reg_sp`), 3=program counter (`reg_pc`).
- R3: `off_src`=1 uses `acc_a` zero-extended, `off_src`=2 uses `acc_b` zero-extended, and `off_src`=3 uses the 16-bit pair {`acc_a`,`acc_b`}.
- R4: Pre-modify (`amod_en`=1, `amod_post`=0) gives `ea` = base + step, or base − step when `amod_dec`=1. The step is `amod_step`+1. `wb_val` equals that `ea`, and `wb_en` pulses for exactly the `done` cycle with `wb_sel`=`base_sel`.
- R5: Post-modify (`amod_post`=1) gives `ea` = the unmodified base, and `wb_val` = base ± step. In any auto-modify request the constant offset has no effect on `ea` or `wb_val`.
- R6: With `indirect`=1, `mem_req` stays high while `mem_addr` holds the pointer until `mem_valid`, then holds the pointer+1 (wrapping) until the next `mem_valid`. `ea` = {first byte, second byte}, and `done` rises in the cycle after the second byte.
- R7: Auto-modify combined with `indirect`=1 or `off_src`≠0 pulses `done` and `illegal` together in the next cycle. In that case `wb_en` stays low, no memory request is made, and `ea` keeps its previous value.
- R8: A `start` pulse that arrives while `mem_req` is high is ignored. The fetch in progress completes unchanged and no extra `done` follows.
- R9: After reset `done`, `illegal`, `wb_en` and `mem_req` are low and `ea` is 0. `done`, `illegal` and `wb_en` are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, sampled when no fetch is in progress |
| base_sel | input | 2 | Base register select (0 X, 1 Y, 2 SP, 3 PC) |
| reg_x | input | 16 | X register value |
| reg_y | input | 16 | Y register value |
| reg_sp | input | 16 | Stack pointer value |
| reg_pc | input | 16 | Program counter value |
| acc_a | input | 8 | Accumulator A |
| acc_b | input | 8 | Accumulator B |
| off_src | input | 2 | Offset source (0 constant, 1 A, 2 B, 3 A:B) |
| cwidth | input | 2 | Constant width (0 short, 1 medium, 2/3 full) |
| cval | input | 16 | Constant offset bits |
| amod_en | input | 1 | Auto-modify the base |
| amod_post | input | 1 | 1 post-modify, 0 pre-modify |
| amod_dec | input | 1 | 1 decrement, 0 increment |
| amod_step | input | 3 | Step magnitude minus one |
| indirect | input | 1 | Fetch the address through memory |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | 16 | Byte read address |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 8 | Read data byte |
| done | output | 1 | Result valid pulse |
| illegal | output | 1 | Refused mode combination pulse |
| ea | output | 16 | Effective address |
| wb_en | output | 1 | Base write-back enable pulse |
| wb_sel | output | 2 | Base register to write back |
| wb_val | output | 16 | Value to write back |

## Verification
A wrong offset extension or base select shows as a wrong `ea` in the very cycle `done` rises, one clock after the request. A stuck fetch state shows as `mem_req` staying high or `done` never arriving, and a wrong byte order shows as swapped halves of `ea` one cycle after the second byte. A missed refusal shows immediately as `wb_en` or `mem_req` rising where only `illegal` should. A lost busy guard shows as an early or extra `done` during a fetch.

// File: rtl/idx_ea_pkg.sv
package idx_ea_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HI   = 2'd1,
        ST_LO   = 2'd2
    } fetch_st_e;

    localparam logic [1:0] BASE_X  = 2'd0;
    localparam logic [1:0] BASE_Y  = 2'd1;
    localparam logic [1:0] BASE_SP = 2'd2;
    localparam logic [1:0] BASE_PC = 2'd3;

    localparam logic [1:0] SRC_CONST = 2'd0;
    localparam logic [1:0] SRC_A     = 2'd1;
    localparam logic [1:0] SRC_B     = 2'd2;
    localparam logic [1:0] SRC_AB    = 2'd3;

    localparam logic [1:0] CW_SHORT = 2'd0;
    localparam logic [1:0] CW_MID   = 2'd1;

endpackage

// File: rtl/idx_off_sel.sv
module idx_off_sel
    import idx_ea_pkg::*;
#(
    parameter int DW      = 8,
    parameter int SHORT_W = 5,
    parameter int MID_W   = 9,
    localparam int AW     = 2 * DW
) (
    input  logic [1:0]    off_src,
    input  logic [1:0]    cwidth,
    input  logic [AW-1:0] cval,
    input  logic [DW-1:0] acc_a,
    input  logic [DW-1:0] acc_b,
    output logic [AW-1:0] offset
);

    logic [AW-1:0] const_ext;

    always_comb begin
        unique case (cwidth)
            CW_SHORT: const_ext = {{(AW-SHORT_W){cval[SHORT_W-1]}}, cval[SHORT_W-1:0]};
            CW_MID:   const_ext = {{(AW-MID_W){cval[MID_W-1]}}, cval[MID_W-1:0]};
            default:  const_ext = cval;
        endcase
    end

    always_comb begin
        unique case (off_src)
            SRC_CONST: offset = const_ext;
            SRC_A:     offset = {{DW{1'b0}}, acc_a};
            SRC_B:     offset = {{DW{1'b0}}, acc_b};
            default:   offset = {acc_a, acc_b};
        endcase
    end

endmodule

// File: rtl/idx_addr_calc.sv
module idx_addr_calc #(
    parameter int AW     = 16,
    parameter int STEP_W = 3
) (
    input  logic [AW-1:0]     base,
    input  logic [AW-1:0]     offset,
    input  logic              amod_en,
    input  logic              amod_post,
    input  logic              amod_dec,
    input  logic [STEP_W-1:0] amod_step,
    input  logic              indirect,
    input  logic              src_is_acc,
    output logic [AW-1:0]     addr,
    output logic [AW-1:0]     mod_base,
    output logic              refuse
);

    localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

    logic [AW-1:0] step_val;

    always_comb begin
        step_val = {{(AW-STEP_W){1'b0}}, amod_step} + ONE;
        mod_base = amod_dec ? (base - step_val) : (base + step_val);
        if (amod_en) begin
            addr = amod_post ? base : mod_base;
        end else begin
            addr = base + offset;
        end
        refuse = amod_en & (indirect | src_is_acc);
    end

endmodule

// File: rtl/idx_ea_gen.sv
module idx_ea_gen
    import idx_ea_pkg::*;
#(
    parameter int DW      = 8,
    parameter int SHORT_W = 5,
    parameter int MID_W   = 9,
    parameter int STEP_W  = 3,
    localparam int AW     = 2 * DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        base_sel,
    input  logic [AW-1:0]     reg_x,
    input  logic [AW-1:0]     reg_y,
    input  logic [AW-1:0]     reg_sp,
    input  logic [AW-1:0]     reg_pc,
    input  logic [DW-1:0]     acc_a,
    input  logic [DW-1:0]     acc_b,
    input  logic [1:0]        off_src,
    input  logic [1:0]        cwidth,
    input  logic [AW-1:0]     cval,
    input  logic              amod_en,
    input  logic              amod_post,
    input  logic              amod_dec,
    input  logic [STEP_W-1:0] amod_step,
    input  logic              indirect,
    output logic              mem_req,
    output logic [AW-1:0]     mem_addr,
    input  logic              mem_valid,
    input  logic [DW-1:0]     mem_rdata,
    output logic              done,
    output logic              illegal,
    output logic [AW-1:0]     ea,
    output logic              wb_en,
    output logic [1:0]        wb_sel,
    output logic [AW-1:0]     wb_val
);

    localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

    typedef struct packed {
        fetch_st_e     st;
        logic [AW-1:0] ea;
        logic [AW-1:0] ptr;
        logic [DW-1:0] hi;
        logic          done;
        logic          illegal;
        logic          wb_en;
        logic [1:0]    wb_sel;
        logic [AW-1:0] wb_val;
    } gen_state_t;

    gen_state_t st_d, st_q;

    logic [AW-1:0] base_val;
    logic [AW-1:0] offset;
    logic [AW-1:0] addr;
    logic [AW-1:0] mod_base;
    logic          refuse;

    always_comb begin
        unique case (base_sel)
            BASE_X:  base_val = reg_x;
            BASE_Y:  base_val = reg_y;
            BASE_SP: base_val = reg_sp;
            default: base_val = reg_pc;
        endcase
    end

    idx_off_sel #(
        .DW      (DW),
        .SHORT_W (SHORT_W),
        .MID_W   (MID_W)
    ) u_off (
        .off_src (off_src),
        .cwidth  (cwidth),
        .cval    (cval),
        .acc_a   (acc_a),
        .acc_b   (acc_b),
        .offset  (offset)
    );

    idx_addr_calc #(
        .AW     (AW),
        .STEP_W (STEP_W)
    ) u_calc (
        .base       (base_val),
        .offset     (offset),
        .amod_en    (amod_en),
        .amod_post  (amod_post),
        .amod_dec   (amod_dec),
        .amod_step  (amod_step),
        .indirect   (indirect),
        .src_is_acc (off_src != SRC_CONST),
        .addr       (addr),
        .mod_base   (mod_base),
        .refuse     (refuse)
    );

    always_comb begin
        st_d         = st_q;
        st_d.done    = 1'b0;
        st_d.illegal = 1'b0;
        st_d.wb_en   = 1'b0;
        unique case (st_q.st)
            ST_IDLE: begin
                if (start) begin
                    if (refuse) begin
                        st_d.done    = 1'b1;
                        st_d.illegal = 1'b1;
                    end else if (indirect) begin
                        st_d.ptr = addr;
                        st_d.st  = ST_HI;
                    end else begin
                        st_d.done   = 1'b1;
                        st_d.ea     = addr;
                        st_d.wb_en  = amod_en;
                        st_d.wb_sel = base_sel;
                        st_d.wb_val = mod_base;
                    end
                end
            end
            ST_HI: begin
                if (mem_valid) begin
                    st_d.hi = mem_rdata;
                    st_d.st = ST_LO;
                end
            end
            ST_LO: begin
                if (mem_valid) begin
                    st_d.ea   = {st_q.hi, mem_rdata};
                    st_d.done = 1'b1;
                    st_d.st   = ST_IDLE;
                end
            end
            default: st_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{st: ST_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_req  = (st_q.st != ST_IDLE);
    assign mem_addr = (st_q.st == ST_LO) ? (st_q.ptr + ONE) : st_q.ptr;
    assign done     = st_q.done;
    assign illegal  = st_q.illegal;
    assign ea       = st_q.ea;
    assign wb_en    = st_q.wb_en;
    assign wb_sel   = st_q.wb_sel;
    assign wb_val   = st_q.wb_val;

endmodule

// File: rtl/idx_ea_chk.sv
module idx_ea_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          indirect,
    input logic          amod_en,
    input logic          mem_req,
    input logic [AW-1:0] mem_addr,
    input logic          mem_valid,
    input logic          done,
    input logic          illegal,
    input logic          wb_en
);

    // R1
    one_cycle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !mem_req && !indirect) |=> done);

    // R4
    wb_only_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (done && !illegal));

    // R6
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

    // R6
    no_done_in_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !done);

    // R7
    refuse_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (done && !wb_en));

    // R7
    refuse_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !mem_req && amod_en && indirect) |=> (!mem_req && illegal));

endmodule

bind idx_ea_gen idx_ea_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .indirect  (indirect),
    .amod_en   (amod_en),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_valid (mem_valid),
    .done      (done),
    .illegal   (illegal),
    .wb_en     (wb_en)
);

// File: tb/sim_idx_ea_gen.sv
`timescale 1ns/1ps
module sim_idx_ea_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  base_sel = '0;
    logic [15:0] reg_x = '0, reg_y = '0, reg_sp = '0, reg_pc = '0;
    logic [7:0]  acc_a = '0, acc_b = '0;
    logic [1:0]  off_src = '0, cwidth = '0;
    logic [15:0] cval = '0;
    logic        amod_en = 1'b0, amod_post = 1'b0, amod_dec = 1'b0;
    logic [2:0]  amod_step = '0;
    logic        indirect = 1'b0;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        mem_valid = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic        done, illegal, wb_en;
    logic [15:0] ea, wb_val;
    logic [1:0]  wb_sel;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    logic [15:0] last_ea = '0;

    always #10 clk = ~clk;

    idx_ea_gen u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .base_sel(base_sel),
        .reg_x(reg_x), .reg_y(reg_y), .reg_sp(reg_sp), .reg_pc(reg_pc),
        .acc_a(acc_a), .acc_b(acc_b), .off_src(off_src), .cwidth(cwidth),
        .cval(cval), .amod_en(amod_en), .amod_post(amod_post),
        .amod_dec(amod_dec), .amod_step(amod_step), .indirect(indirect),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
        .mem_rdata(mem_rdata), .done(done), .illegal(illegal), .ea(ea),
        .wb_en(wb_en), .wb_sel(wb_sel), .wb_val(wb_val)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] sext(input logic [15:0] v, input int w);
        logic [15:0] r;
        for (int i = 0; i < 16; i++) r[i] = (i < w) ? v[i] : v[w-1];
        return r;
    endfunction

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    function automatic logic [15:0] base_of(input logic [1:0] s);
        case (s)
            2'd0: return reg_x;
            2'd1: return reg_y;
            2'd2: return reg_sp;
            default: return reg_pc;
        endcase
    endfunction

    function automatic logic [15:0] off_of();
        case (off_src)
            2'd0: begin
                if (cwidth == 2'd0) return sext(cval, 5);
                else if (cwidth == 2'd1) return sext(cval, 9);
                else return cval;
            end
            2'd1: return {8'h00, acc_a};
            2'd2: return {8'h00, acc_b};
            default: return {acc_a, acc_b};
        endcase
    endfunction

    // Inputs must already be set; issues one request and checks it.
    task automatic run_txn(input string req, input int dly, input bit poke);
        logic [15:0] base, stepv, modb, ptr, exp_ea;
        bit ill;
        base  = base_of(base_sel);
        stepv = {13'd0, amod_step} + 16'd1;
        modb  = amod_dec ? base - stepv : base + stepv;
        ill   = amod_en && (indirect || off_src != 2'd0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (ill) begin
            // R7
            chk(done && illegal && !wb_en && !mem_req, {req, " R7 refuse"},
                {done, illegal, wb_en, mem_req}, 4'b1100);
            chk(ea == last_ea, {req, " R7 ea held"}, ea, last_ea);
        end else if (amod_en) begin
            exp_ea = amod_post ? base : modb;
            chk(done && !illegal && ea == exp_ea, {req, amod_post ? " R5 ea" : " R4 ea"},
                {done, illegal, ea}, {2'b10, exp_ea});
            chk(wb_en && wb_val == modb && wb_sel == base_sel,
                {req, amod_post ? " R5 wb" : " R4 wb"}, {wb_en, wb_sel, wb_val},
                {1'b1, base_sel, modb});
            last_ea = exp_ea;
        end else if (indirect) begin
            ptr = base + off_of();
            exp_ea = {mem_byte(ptr), mem_byte(ptr + 16'd1)};
            chk(mem_req && !done && mem_addr == ptr, {req, " R6 first addr"},
                {mem_req, done, mem_addr}, {2'b10, ptr});
            for (int i = 0; i < dly; i++) begin
                if (poke && i == 0) begin
                    indirect = 1'b0;
                    start = 1'b1;
                end
                @(negedge clk);
                start = 1'b0;
                chk(mem_req && !done && mem_addr == ptr, {req, " R8 R6 hold hi"},
                    {mem_req, done, mem_addr}, {2'b10, ptr});
            end
            mem_valid = 1'b1;
            mem_rdata = mem_byte(mem_addr);
            @(negedge clk);
            mem_valid = 1'b0;
            chk(mem_req && !done && mem_addr == ptr + 16'd1, {req, " R6 second addr"},
                {mem_req, done, mem_addr}, {2'b10, ptr + 16'd1});
            for (int i = 0; i < dly; i++) @(negedge clk);
            mem_valid = 1'b1;
            mem_rdata = mem_byte(mem_addr);
            @(negedge clk);
            mem_valid = 1'b0;
            chk(done && !mem_req && !wb_en && ea == exp_ea, {req, " R6 ea"},
                {done, mem_req, wb_en, ea}, {3'b100, exp_ea});
            last_ea = exp_ea;
        end else begin
            exp_ea = base + off_of();
            chk(done && !illegal && !wb_en && ea == exp_ea,
                {req, off_src == 2'd0 ? " R1 R2 ea" : " R3 ea"},
                {done, illegal, wb_en, ea}, {3'b100, exp_ea});
            last_ea = exp_ea;
        end
        @(negedge clk);
        // R9 single-cycle pulses, R8 no extra done
        chk(!done && !wb_en && !illegal, {req, " R9 R8 pulse"}, {done, wb_en, illegal}, 3'b000);
    endtask

    task automatic set_plain(input logic [1:0] s, input logic [1:0] src, input logic [1:0] cw,
                             input logic [15:0] c);
        base_sel = s; off_src = src; cwidth = cw; cval = c;
        amod_en = 1'b0; amod_post = 1'b0; amod_dec = 1'b0; amod_step = '0; indirect = 1'b0;
    endtask

    task automatic set_mod(input logic [1:0] s, input bit post, input bit dec, input logic [2:0] st);
        base_sel = s; off_src = 2'd0; amod_en = 1'b1; amod_post = post;
        amod_dec = dec; amod_step = st; indirect = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4321));
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(!done && !illegal && !wb_en && !mem_req && ea == 16'h0, "R9 reset",
            {done, illegal, wb_en, mem_req, ea}, 20'h0);
        rst_n = 1'b1;
        @(negedge clk);

        reg_x = 16'h1000; reg_y = 16'h2000; reg_sp = 16'h3000; reg_pc = 16'hFFFF;
        acc_a = 8'hFF; acc_b = 8'h80;
        // R1 short negative, R2 X
        set_plain(2'd0, 2'd0, 2'd0, 16'hFFF0); run_txn("short -16", 0, 0);
        set_plain(2'd1, 2'd0, 2'd0, 16'h000F); run_txn("short +15", 0, 0);
        set_plain(2'd2, 2'd0, 2'd1, 16'h7F00); run_txn("mid -256", 0, 0);
        set_plain(2'd3, 2'd0, 2'd2, 16'h0001); run_txn("full wrap", 0, 0);
        set_plain(2'd3, 2'd0, 2'd3, 16'h8000); run_txn("full code3", 0, 0);
        // R3
        set_plain(2'd0, 2'd1, 2'd0, 16'h0000); run_txn("acc A", 0, 0);
        set_plain(2'd1, 2'd2, 2'd0, 16'h0000); run_txn("acc B", 0, 0);
        set_plain(2'd2, 2'd3, 2'd0, 16'h0000); run_txn("acc AB", 0, 0);
        // R4 pre-dec wrap, R5 post-inc wrap with constant ignored
        reg_x = 16'h0003; cval = 16'h1234;
        set_mod(2'd0, 1'b0, 1'b1, 3'd7); run_txn("pre dec 8", 0, 0);
        reg_y = 16'hFFFC;
        set_mod(2'd1, 1'b1, 1'b0, 3'd7); run_txn("post inc 8", 0, 0);
        set_mod(2'd2, 1'b0, 1'b0, 3'd0); run_txn("pre inc 1", 0, 0);
        // R7 refusals
        set_mod(2'd0, 1'b0, 1'b0, 3'd2); off_src = 2'd1; run_txn("mod+acc", 0, 0);
        set_mod(2'd1, 1'b1, 1'b0, 3'd2); indirect = 1'b1; run_txn("mod+ind", 0, 0);
        // R6 pointer at top of memory, R8 poke while busy
        reg_sp = 16'hFFFF;
        set_plain(2'd2, 2'd0, 2'd2, 16'h0000); indirect = 1'b1; run_txn("ind wrap", 2, 0);
        reg_x = 16'h4455;
        set_plain(2'd0, 2'd3, 2'd0, 16'h0000); indirect = 1'b1; run_txn("ind busy", 3, 1);

        for (int n = 0; n < 400; n++) begin
            reg_x = 16'($urandom); reg_y = 16'($urandom);
            reg_sp = 16'($urandom); reg_pc = 16'($urandom);
            acc_a = 8'($urandom); acc_b = 8'($urandom);
            base_sel = 2'($urandom); off_src = 2'($urandom); cwidth = 2'($urandom);
            cval = 16'($urandom);
            amod_en = ($urandom % 3) == 0; amod_post = 1'($urandom);
            amod_dec = 1'($urandom); amod_step = 3'($urandom);
            indirect = ($urandom % 3) == 0;
            if (amod_en && ($urandom % 4) != 0) begin
                indirect = 1'b0; off_src = 2'd0;
            end
            run_txn("rand", int'($urandom % 3), ($urandom % 5) == 0);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule